// File: doc/BRIEF.md
# Vectored Interrupt Controller with Context Save

This block arbitrates interrupt requests for a small 4-bit processor core. Six sources feed it one-cycle request pulses: two external pins, three timer underflows and a supply-voltage-drop detector. Each pulse sets a latched request flag. Software can write a per-source enable mask and can clear flags through a small register write port. The core marks each completed instruction with a boundary strobe, and the block decides only at those strobes whether to divert control.

When a request is taken, the block raises a one-cycle take signal with a fixed vector address in code page 1. In the same edge it clears the global enable and the serviced request flag. It also saves the return address and a working-register context (data pointer, carry, skip and the A and B registers) into a single-entry hardware stack. A return-from-interrupt opcode at a boundary raises a one-cycle restore strobe, and the saved address and context are then presented to the core. The enable-interrupts opcode arms the global enable, and the enable takes effect only when the following instruction completes. As a result, enable followed directly by return lets interrupts in only once the main routine has resumed.

Top module: `irq_vec_ctl`

## Requirements
- R1: After reset, take, restore and gie are 0, and all request flags and enable bits are 0.
- R2: A request pulse on src_pulse[i] sets flag req_pend[i], and the flag stays set until it is cleared. Bit order is 0 pin 0, 1 pin 1, 2 timer 1, 3 timer 2, 4 timer 3, 5 voltage drop. A write with reg_we=1 and reg_sel=1 clears every flag whose reg_wdata bit is 1. A pulse in the same cycle as a clear leaves the flag set.
- R3: A request is taken at an edge where instr_done=1 only if gie=1 and at least one flag has its enable bit set. take is high for exactly the one cycle after that edge. No request is taken without instr_done.
- R4: take_vec equals 0x80 plus the source offset: 0x0 for pin 0, 0x2 for pin 1, 0x4 for timer 1, 0x6 for timer 2, 0x8 for timer 3 and 0xE for voltage drop. When several enabled flags are pending, the lowest bit index wins and the others stay latched.
- R5: Taking a request clears gie and the serviced flag only. The voltage-drop flag (bit 5) stays set when it is serviced.
- R6: Taking a request stores pc_ret and ctx_in from the boundary cycle, and they appear on rest_addr and rest_ctx from the next cycle on.
- R7: op_ei at one boundary makes gie read 1 right after the next boundary edge, not before. No request is taken at that next boundary.
- R8: op_rti at a boundary gives a one-cycle restore pulse in the following cycle, with the saved address and context on rest_addr and rest_ctx. No request is taken at an op_rti boundary.
- R9: A write with reg_we=1 and reg_sel=0 loads the enable mask from reg_wdata. A pending flag whose enable bit is 0 is not taken and stays latched.
- R10: A take at a boundary that also carries op_ei cancels that enable, so gie stays 0 at the following boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 6 | Request pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 writes the enable mask, 1 clears flags |
| reg_wdata | input | 6 | Write data, one bit per source |
| instr_done | input | 1 | Instruction boundary strobe |
| op_ei | input | 1 | Completed instruction was enable-interrupts |
| op_rti | input | 1 | Completed instruction was return-from-interrupt |
| pc_ret | input | PC_W | Address to resume the main routine at |
| ctx_in | input | CTX_W | Live working-register context |
| take | output | 1 | One-cycle interrupt taken strobe |
| take_vec | output | PC_W | Vector address for the taken source |
| gie | output | 1 | Global interrupt enable |
| req_pend | output | 6 | Latched request flags |
| restore | output | 1 | One-cycle context restore strobe |
| rest_addr | output | PC_W | Saved return address |
| rest_ctx | output | CTX_W | Saved working-register context |

## Verification
If the enable-delay state is wrong, gie rises one boundary early or late, and take then appears or goes missing at the very next boundary strobe. A wrong flag update shows on req_pend in the cycle after the pulse, clear or take, and the voltage-drop bit is the case most at risk after its own service. Priority or vector errors show on take_vec in the single take cycle. A bad context register only shows when restore is pulsed, so the bench reads the saved values both right after a take and after a later return.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NSRC      = 6;
  localparam int SRC_PIN0  = 0;
  localparam int SRC_PIN1  = 1;
  localparam int SRC_TMR1  = 2;
  localparam int SRC_TMR2  = 3;
  localparam int SRC_TMR3  = 4;
  localparam int SRC_VDROP = 5;

  // flags that survive their own service
  localparam logic [NSRC-1:0] STICKY_MASK = 6'b10_0000;

  // offset inside the vector page for a source index
  function automatic logic [3:0] vec_offset(input int idx);
    if (idx == SRC_VDROP) return 4'hE;
    return 4'(2 * idx);
  endfunction
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int          N      = 6,
  parameter logic [N-1:0] STICKY = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] sw_clr_i,
  input  logic [N-1:0] svc_clr_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_data_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] en_o
);
  logic [N-1:0] flag_q, flag_d;
  logic [N-1:0] en_q, en_d;
  logic         flag_ce;

  always_comb begin
    flag_ce = |{set_i, sw_clr_i, svc_clr_i};
    // a new pulse outranks both kinds of clear
    flag_d  = (flag_q & ~sw_clr_i & ~(svc_clr_i & ~STICKY)) | set_i;
    en_d    = en_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      if (flag_ce) flag_q <= flag_d;
      if (en_we_i) en_q   <= en_d;
    end
  end

  assign pend_o = flag_q;
  assign en_o   = en_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int N  = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // lowest index has the highest priority: scan downward, last hit wins
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IW'(i);
      end
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/irq_gie_ctl.sv
module irq_gie_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic bnd_i,
  input  logic ei_i,
  input  logic take_i,
  output logic gie_o
);
  logic gie_q, gie_d;
  logic arm_q, arm_d;

  always_comb begin
    gie_d = gie_q;
    arm_d = arm_q;
    if (take_i) begin
      gie_d = 1'b0;
      arm_d = 1'b0;           // a pending enable is dropped by the take
    end else begin
      gie_d = gie_q | arm_q;  // enable lands one instruction after its opcode
      arm_d = ei_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q <= 1'b0;
      arm_q <= 1'b0;
    end else if (bnd_i) begin
      gie_q <= gie_d;
      arm_q <= arm_d;
    end
  end

  assign gie_o = gie_q;
endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack #(
  parameter int AW = 13,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] ctx_i,
  input  logic          pop_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] ctx_o,
  output logic          pop_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] ctx_q;
  logic          pop_q, pop_d;

  always_comb pop_d = pop_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ctx_q  <= '0;
      pop_q  <= 1'b0;
    end else begin
      if (push_i) begin
        addr_q <= addr_i;
        ctx_q  <= ctx_i;
      end
      pop_q <= pop_d;
    end
  end

  assign addr_o = addr_q;
  assign ctx_o  = ctx_q;
  assign pop_o  = pop_q;
endmodule

// File: rtl/irq_vec_ctl.sv
module irq_vec_ctl
  import irq_vec_pkg::*;
#(
  parameter int PC_W     = 13,
  parameter int PAGE_W   = 7,
  parameter int VEC_PAGE = 1,
  parameter int CTX_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_pulse,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [NSRC-1:0]  reg_wdata,
  input  logic             instr_done,
  input  logic             op_ei,
  input  logic             op_rti,
  input  logic [PC_W-1:0]  pc_ret,
  input  logic [CTX_W-1:0] ctx_in,
  output logic             take,
  output logic [PC_W-1:0]  take_vec,
  output logic             gie,
  output logic [NSRC-1:0]  req_pend,
  output logic             restore,
  output logic [PC_W-1:0]  rest_addr,
  output logic [CTX_W-1:0] rest_ctx
);
  localparam int IW = $clog2(NSRC);
  localparam logic [PC_W-1:0] VEC_BASE = PC_W'(VEC_PAGE) << PAGE_W;

  // reset: asserted at once, released after two clean edges
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [NSRC-1:0] en_mask, hit, grant, svc_clr, sw_clr;
  logic [IW-1:0]   grant_idx;
  logic            any_hit, take_now, en_we, gie_w;
  logic            take_q, take_d;
  logic [PC_W-1:0] vec_q, vec_d;

  always_comb begin
    sw_clr   = (reg_we && reg_sel) ? reg_wdata : '0;
    en_we    = reg_we && !reg_sel;
    hit      = req_pend & en_mask;
    take_now = instr_done && !op_rti && gie_w && any_hit;
    svc_clr  = take_now ? grant : '0;
    take_d   = take_now;
    vec_d    = VEC_BASE | PC_W'(vec_offset(int'(grant_idx)));
  end

  irq_req_bank #(.N(NSRC), .STICKY(STICKY_MASK)) u_bank (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .set_i     (src_pulse),
    .sw_clr_i  (sw_clr),
    .svc_clr_i (svc_clr),
    .en_we_i   (en_we),
    .en_data_i (reg_wdata),
    .pend_o    (req_pend),
    .en_o      (en_mask)
  );

  irq_prio_sel #(.N(NSRC)) u_prio (
    .req_i   (hit),
    .grant_o (grant),
    .idx_o   (grant_idx),
    .any_o   (any_hit)
  );

  irq_gie_ctl u_gie (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .bnd_i  (instr_done),
    .ei_i   (op_ei),
    .take_i (take_now),
    .gie_o  (gie_w)
  );

  irq_ctx_stack #(.AW(PC_W), .CW(CTX_W)) u_stack (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .push_i (take_now),
    .addr_i (pc_ret),
    .ctx_i  (ctx_in),
    .pop_i  (instr_done && op_rti),
    .addr_o (rest_addr),
    .ctx_o  (rest_ctx),
    .pop_o  (restore)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      take_q <= take_d;
      if (take_now) vec_q <= vec_d;
    end
  end

  assign take     = take_q;
  assign take_vec = vec_q;
  assign gie      = gie_w;
endmodule

// File: rtl/irq_vec_ctl_chk.sv
module irq_vec_ctl_chk #(
  parameter int N    = 6,
  parameter int PC_W = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    src_pulse,
  input logic            instr_done,
  input logic            op_rti,
  input logic            take,
  input logic [PC_W-1:0] take_vec,
  input logic            gie,
  input logic [N-1:0]    req_pend,
  input logic            restore,
  input logic [N-1:0]    grant
);
  // R2: a pulse is visible as a latched flag one cycle later
  a_r2_pulse_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pulse != '0) |=> ((req_pend & $past(src_pulse)) == $past(src_pulse)));

  // R3: take only follows a boundary seen with gie set and no return opcode
  a_r3_take_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ($past(instr_done) && $past(gie) && !$past(op_rti)));

  // R3: take never lasts two cycles
  a_r3_take_single: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take);

  // R4: at most one source granted
  a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R5: global enable is low once a take is presented
  a_r5_gie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !gie);

  // R5: voltage-drop flag survives its own service
  a_r5_vdrop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_vec[3:0] == 4'hE) |-> req_pend[N-1]);

  // R7: gie only rises on a boundary edge
  a_r7_gie_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gie) |-> $past(instr_done));

  // R8: restore pulse follows a return boundary, and no take follows one
  a_r8_restore_origin: assert property (@(posedge clk) disable iff (!rst_n)
    restore |-> $past(instr_done && op_rti));

  a_r8_no_take_on_return: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_done && op_rti) |=> !take);
endmodule

bind irq_vec_ctl irq_vec_ctl_chk #(.N(irq_vec_pkg::NSRC), .PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .src_pulse  (src_pulse),
  .instr_done (instr_done),
  .op_rti     (op_rti),
  .take       (take),
  .take_vec   (take_vec),
  .gie        (gie),
  .req_pend   (req_pend),
  .restore    (restore),
  .grant      (grant)
);

// File: tb/irq_vec_ctl_test.sv
`timescale 1ns/1ps
module irq_vec_ctl_test;
  localparam int PC_W  = 13;
  localparam int CTX_W = 16;
  localparam int NSTEP = 29;
  localparam logic [PC_W-1:0] BASE = 13'h080;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [5:0]       src_pulse;
  logic             reg_we, reg_sel, instr_done, op_ei, op_rti;
  logic [5:0]       reg_wdata;
  logic [PC_W-1:0]  pc_ret;
  logic [CTX_W-1:0] ctx_in;
  logic             take, gie, restore;
  logic [PC_W-1:0]  take_vec, rest_addr;
  logic [5:0]       req_pend;
  logic [CTX_W-1:0] rest_ctx;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  irq_vec_ctl uut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .instr_done(instr_done),
    .op_ei(op_ei), .op_rti(op_rti), .pc_ret(pc_ret), .ctx_in(ctx_in),
    .take(take), .take_vec(take_vec), .gie(gie), .req_pend(req_pend),
    .restore(restore), .rest_addr(rest_addr), .rest_ctx(rest_ctx)
  );

  // {src, bnd ei rti we sel, wdata, x_take, x_vec_offset, x_gie, x_pend}
  localparam logic [28:0] TBL [NSTEP] = '{
    {6'b000000, 5'b00010, 6'b111111, 1'b0, 4'h0, 1'b0, 6'b000000}, // R9 enable all
    {6'b000100, 5'b00000, 6'b000000, 1'b0, 4'h0, 1'b0, 6'b000100}, // R2 latch
    {6'b000000, 5'b10000, 6'b000000, 1'b0, 4'h0, 1'b0, 6'b000100}, // R3 gie low
    {6'b000000, 5'b11000, 6'b000000, 1'b0, 4'h0, 1'b0, 6'b000100}, // R7 ei
    {6'b000000, 5'b10000, 6'b000000, 1'b0, 4'h0, 1'b1, 6'b000100}, // R7 gie up
    {6'b000000, 5'b10000, 6'b000000, 1'b1, 4'h4, 1'b0, 6'b000000}, // R4 timer 1
    {6'b100001, 5'b00000, 6'b000000, 1'b0, 4'h0, 1'b0, 6'b100001},
    {6'b000000, 5'b11000, 6'b000000, 1'b0, 4'h0, 1'b0, 6'b100001},
    {6'b000000, 5'b10000, 6'b000000, 1'b0, 4'h0, 1'b1, 6'b100001},
    {6'b000000, 5'b10000, 6'b000000, 1'b1, 4'h0, 1'b0, 6'b100000}, // R4 pin 0 first
    {6'b000000, 5'b11000, 6'b000000, 1'b0, 4'h0, 1'b0, 6'b100000},
    {6'b000000, 5'b10000, 6'b000000, 1'b0, 4'h0, 1'b1, 6'b100000},
    {6'b000000, 5'b10000, 6'b000000, 1'b1, 4'hE, 1'b0, 6'b100000}, // R5 sticky
    {6'b000000, 5'b00011, 6'b100000, 1'b0, 4'h0, 1'b0, 6'b000000}, // R2 sw clear
    {6'b010000, 5'b00010, 6'b000000, 1'b0, 4'h0, 1'b0, 6'b010000}, // R9 disable
    {6'b000000, 5'b11000, 6'b000000, 1'b0, 4'h0, 1'b0, 6'b010000},
    {6'b000000, 5'b10000, 6'b000000, 1'b0, 4'h0, 1'b1, 6'b010000},
    {6'b000000, 5'b10000, 6'b000000, 1'b0, 4'h0, 1'b1, 6'b010000}, // R9 masked
    {6'b000000, 5'b00010, 6'b010000, 1'b0, 4'h0, 1'b1, 6'b010000},
    {6'b000000, 5'b10000, 6'b000000, 1'b1, 4'h8, 1'b0, 6'b000000}, // R4 timer 3
    {6'b001010, 5'b00011, 6'b001010, 1'b0, 4'h0, 1'b0, 6'b001010}, // R2 set wins
    {6'b000000, 5'b00010, 6'b111111, 1'b0, 4'h0, 1'b0, 6'b001010},
    {6'b000000, 5'b11000, 6'b000000, 1'b0, 4'h0, 1'b0, 6'b001010},
    {6'b000000, 5'b10000, 6'b000000, 1'b0, 4'h0, 1'b1, 6'b001010},
    {6'b000000, 5'b10000, 6'b000000, 1'b1, 4'h2, 1'b0, 6'b001000}, // R4 pin 1
    {6'b000000, 5'b11000, 6'b000000, 1'b0, 4'h0, 1'b0, 6'b001000},
    {6'b000000, 5'b10000, 6'b000000, 1'b0, 4'h0, 1'b1, 6'b001000},
    {6'b000000, 5'b10000, 6'b000000, 1'b1, 4'h6, 1'b0, 6'b000000}, // R4 timer 2
    {6'b000001, 5'b10000, 6'b000000, 1'b0, 4'h0, 1'b0, 6'b000001}  // R3 gie low
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [5:0] s, input logic b, input logic e,
                      input logic r, input logic w, input logic sl,
                      input logic [5:0] d);
    @(negedge clk);
    src_pulse = s; instr_done = b; op_ei = e; op_rti = r;
    reg_we = w; reg_sel = sl; reg_wdata = d;
    @(posedge clk);
    #1;
    src_pulse = '0; instr_done = 1'b0; op_ei = 1'b0; op_rti = 1'b0;
    reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    src_pulse = '0; instr_done = 1'b0; op_ei = 1'b0; op_rti = 1'b0;
    reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    pc_ret = '0; ctx_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 take after reset", take, 0);
    chk("R1 gie after reset", gie, 0);
    chk("R1 flags after reset", req_pend, 0);
    chk("R1 restore after reset", restore, 0);

    for (int i = 0; i < NSTEP; i++) begin
      logic [28:0] t;
      t = TBL[i];
      pc_ret = PC_W'(i);
      ctx_in = CTX_W'(i);
      step(t[28:23], t[22], t[21], t[20], t[19], t[18], t[17:12]);
      chk($sformatf("R3 take step %0d", i), take, t[11]);
      if (t[11]) chk($sformatf("R4 vector step %0d", i), take_vec, BASE | PC_W'(t[10:7]));
      chk($sformatf("R5 gie step %0d", i), gie, t[6]);
      chk($sformatf("R2 flags step %0d", i), req_pend, t[5:0]);
    end

    // R6: context push on take (pin 0 pending from the last table step)
    step(6'b0, 1, 1, 0, 0, 0, 6'b0);
    step(6'b0, 1, 0, 0, 0, 0, 6'b0);
    pc_ret = 13'h0ABC; ctx_in = 16'h5A3C;
    step(6'b0, 1, 0, 0, 0, 0, 6'b0);
    pc_ret = 13'h0111; ctx_in = 16'h0F0F;
    chk("R6 take", take, 1);
    chk("R6 vector", take_vec, BASE);
    chk("R6 saved address", rest_addr, 13'h0ABC);
    chk("R6 saved context", rest_ctx, 16'h5A3C);

    // R7/R8: enable then return; interrupt lands only after return
    step(6'b000010, 0, 0, 0, 0, 0, 6'b0);
    step(6'b0, 1, 1, 0, 0, 0, 6'b0);
    chk("R7 gie held after ei", gie, 0);
    step(6'b0, 1, 0, 1, 0, 0, 6'b0);
    chk("R8 restore pulse", restore, 1);
    chk("R8 restored address", rest_addr, 13'h0ABC);
    chk("R8 restored context", rest_ctx, 16'h5A3C);
    chk("R7 gie after return", gie, 1);
    chk("R7 no take at return", take, 0);
    step(6'b0, 0, 0, 0, 0, 0, 6'b0);
    chk("R8 restore single cycle", restore, 0);
    step(6'b0, 1, 0, 0, 0, 0, 6'b0);
    chk("R7 take in main routine", take, 1);
    chk("R7 vector pin 1", take_vec, BASE | 13'h2);

    // R8: no take at a return boundary even with gie set
    step(6'b0, 1, 1, 0, 0, 0, 6'b0);
    step(6'b0, 1, 0, 0, 0, 0, 6'b0);
    step(6'b000001, 0, 0, 0, 0, 0, 6'b0);
    step(6'b0, 1, 0, 1, 0, 0, 6'b0);
    chk("R8 take blocked at return", take, 0);
    chk("R8 restore with gie set", restore, 1);
    chk("R8 flag kept", req_pend, 6'b000001);
    step(6'b0, 1, 0, 0, 0, 0, 6'b0);
    chk("R8 deferred take", take, 1);
    chk("R8 deferred vector", take_vec, BASE);

    // R3: no take without a boundary; R10: take cancels a same-boundary ei
    step(6'b0, 1, 1, 0, 0, 0, 6'b0);
    step(6'b0, 1, 0, 0, 0, 0, 6'b0);
    step(6'b000100, 0, 0, 0, 0, 0, 6'b0);
    step(6'b0, 0, 0, 0, 0, 0, 6'b0);
    chk("R3 no take off boundary", take, 0);
    step(6'b0, 1, 1, 0, 0, 0, 6'b0);
    chk("R10 take with ei", take, 1);
    chk("R10 vector timer 1", take_vec, BASE | 13'h4);
    step(6'b0, 1, 0, 0, 0, 0, 6'b0);
    chk("R10 gie stays low", gie, 0);
    step(6'b0, 1, 0, 0, 0, 0, 6'b0);
    chk("R10 gie still low", gie, 0);

    finish_run();
  end
endmodule